// File: doc/BRIEF.md
# Three-Way Compare Branch Target Unit

This block resolves a compare-and-branch that has three outcomes, the kind a compiler emits for binary-search dispatch over sparse switch cases. In one cycle it compares two signed 64-bit operands, picks one of several PC-relative displacements packed into a single 33-bit immediate, and forms the 48-bit next PC. The result is registered and appears one cycle after a valid input strobe.

In three-way mode the immediate holds three signed 11-bit displacements, one each for less, equal and greater, and the branch is always taken. In two-way mode the immediate holds two signed 16-bit displacements for less and greater. Equal operands fall through to the next sequential instruction, which is 8 bytes on, and the taken flag stays low.

The target is not formed with a full 48-bit add. Each candidate adds its displacement to the low 16 bits of the PC, and that add leaves a carry of -1, 0 or +1. The upper 32 bits of the PC are precomputed as decremented, unchanged and incremented. After the compare picks a candidate, its carry picks one of those three upper values.

Top module: `tbu_branch3`

## Requirements
- R1: While rst_n is low, out_valid, taken and next_pc are all zero.
- R2: out_valid is high in the cycle after in_valid was high, and low in the cycle after in_valid was low.
- R3: With mode = 0 (three-way), the less displacement is imm[10:0], the equal displacement is imm[21:11] and the greater displacement is imm[32:22]. Each is a signed two's-complement byte offset.
- R4: The operands are compared as signed 64-bit two's-complement numbers. opa < opb selects less, opa == opb selects equal, and opa > opb selects greater, including when the operands have opposite signs.
- R5: In three-way mode, taken is 1 and next_pc equals pc plus the selected sign-extended displacement.
- R6: With mode = 1 (two-way), opa < opb gives pc plus the signed imm[15:0], and opa > opb gives pc plus the signed imm[31:16], both with taken = 1. imm[32] has no effect in this mode.
- R7: In two-way mode with equal operands, next_pc is pc + 8 and taken is 0.
- R8: next_pc wraps modulo 2^48, both above the top of the address space and below zero.
- R9: A carry or borrow out of the low 16 bits of the PC is applied to the upper 32 bits, so next_pc equals the full 48-bit sum.
- R10: In a cycle with in_valid low, next_pc and taken keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: inputs hold a branch to resolve |
| mode | input | 1 | 0 = three-way, 1 = two-way with fall-through |
| pc | input | 48 | Byte address of the branch instruction |
| imm | input | 33 | Packed displacement field |
| opa | input | 64 | First compare operand |
| opb | input | 64 | Second compare operand |
| out_valid | output | 1 | Registered result valid |
| next_pc | output | 48 | Resolved next program counter |
| taken | output | 1 | 1 when the branch redirects, 0 on fall-through |

## Verification
The bench builds the block with its default parameters: a 48-bit PC, a 16-bit low add window, 64-bit operands, 11-bit three-way fields and 16-bit two-way fields. A 16-bit window with 16-bit displacements keeps the low-add carry inside -1..+1 while letting both the carry and the borrow occur, so PCs picked just below and just above multiples of 65536 drive every upper-part choice. Those parameters also keep the 48-bit wraparound within reach, using PCs at the very top of the space and at zero. Operands with opposite signs and the most negative value separate a signed compare from an unsigned one.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  localparam int unsigned TBU_PC_W    = 48;
  localparam int unsigned TBU_LO_W    = 16;
  localparam int unsigned TBU_DATA_W  = 64;
  localparam int unsigned TBU_IMM_W   = 33;
  localparam int unsigned TBU_D3_W    = 11;
  localparam int unsigned TBU_D2_W    = 16;
  localparam int unsigned TBU_FALL_B  = 8;
  localparam int unsigned TBU_NCAND   = 3;

  typedef enum logic [1:0] {
    CMP_LT = 2'd0,
    CMP_EQ = 2'd1,
    CMP_GT = 2'd2
  } cmp_e;

  typedef enum logic {
    MODE_TRI = 1'b0,
    MODE_DUO = 1'b1
  } mode_e;
endpackage

// File: rtl/tbu_cmp.sv
module tbu_cmp #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              lt,
  output logic              eq,
  output logic              gt
);
  // One extra bit keeps the sign of the difference exact for any operand pair.
  logic [DATA_W:0] diff;
  logic            flag_s;
  logic            flag_z;

  always_comb begin
    diff   = {opa[DATA_W-1], opa} - {opb[DATA_W-1], opb};
    flag_s = diff[DATA_W];
    flag_z = (diff == '0);
    lt     = flag_s;
    eq     = flag_z;
    gt     = !flag_s && !flag_z;
  end
endmodule

// File: rtl/tbu_unpack.sv
module tbu_unpack #(
  parameter int unsigned IMM_W  = 33,
  parameter int unsigned D3_W   = 11,
  parameter int unsigned D2_W   = 16,
  parameter int unsigned SUM_W  = 17,
  parameter int unsigned FALL_B = 8
) (
  input  logic             mode,
  input  logic [IMM_W-1:0] imm,
  output logic [SUM_W-1:0] d_lt,
  output logic [SUM_W-1:0] d_eq,
  output logic [SUM_W-1:0] d_gt
);
  localparam int unsigned X3 = SUM_W - D3_W;
  localparam int unsigned X2 = SUM_W - D2_W;

  logic [D3_W-1:0] f3_lt, f3_eq, f3_gt;
  logic [D2_W-1:0] f2_lo, f2_hi;

  always_comb begin
    f3_lt = imm[D3_W-1:0];
    f3_eq = imm[2*D3_W-1:D3_W];
    f3_gt = imm[3*D3_W-1:2*D3_W];
    f2_lo = imm[D2_W-1:0];
    f2_hi = imm[2*D2_W-1:D2_W];
    if (mode == tbu_pkg::MODE_DUO) begin
      d_lt = {{X2{f2_lo[D2_W-1]}}, f2_lo};
      d_eq = SUM_W'(FALL_B);
      d_gt = {{X2{f2_hi[D2_W-1]}}, f2_hi};
    end else begin
      d_lt = {{X3{f3_lt[D3_W-1]}}, f3_lt};
      d_eq = {{X3{f3_eq[D3_W-1]}}, f3_eq};
      d_gt = {{X3{f3_gt[D3_W-1]}}, f3_gt};
    end
  end
endmodule

// File: rtl/tbu_lo_add.sv
module tbu_lo_add #(
  parameter int unsigned LO_W = 16
) (
  input  logic [LO_W-1:0] pc_lo,
  input  logic [LO_W:0]   disp,
  output logic [LO_W-1:0] sum_lo,
  output logic [1:0]      adj
);
  // Two guard bits: the top pair reads 00 = none, 01 = carry, 11 = borrow.
  logic [LO_W+1:0] sum;

  always_comb begin
    sum    = {2'b00, pc_lo} + {disp[LO_W], disp};
    sum_lo = sum[LO_W-1:0];
    adj    = sum[LO_W+1:LO_W];
  end
endmodule

// File: rtl/tbu_hi_sel.sv
module tbu_hi_sel #(
  parameter int unsigned HI_W = 32
) (
  input  logic [HI_W-1:0] hi,
  input  logic [1:0]      adj,
  output logic [HI_W-1:0] hi_out
);
  logic [HI_W-1:0] hi_inc;
  logic [HI_W-1:0] hi_dec;

  always_comb begin
    hi_inc = hi + HI_W'(1);
    hi_dec = hi - HI_W'(1);
    unique case (adj)
      2'b01:   hi_out = hi_inc;
      2'b11:   hi_out = hi_dec;
      default: hi_out = hi;
    endcase
  end
endmodule

// File: rtl/tbu_branch3.sv
module tbu_branch3 #(
  parameter int unsigned PC_W   = tbu_pkg::TBU_PC_W,
  parameter int unsigned LO_W   = tbu_pkg::TBU_LO_W,
  parameter int unsigned DATA_W = tbu_pkg::TBU_DATA_W,
  parameter int unsigned IMM_W  = tbu_pkg::TBU_IMM_W,
  parameter int unsigned D3_W   = tbu_pkg::TBU_D3_W,
  parameter int unsigned D2_W   = tbu_pkg::TBU_D2_W,
  parameter int unsigned FALL_B = tbu_pkg::TBU_FALL_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              mode,
  input  logic [PC_W-1:0]   pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken
);
  import tbu_pkg::*;

  localparam int unsigned HI_W  = PC_W - LO_W;
  localparam int unsigned SUM_W = LO_W + 1;
  localparam int unsigned NC    = TBU_NCAND;

  logic             c_lt, c_eq, c_gt;
  cmp_e             outcome;
  logic [SUM_W-1:0] disp_v [NC];
  logic [LO_W-1:0]  cand_lo [NC];
  logic [1:0]       cand_adj [NC];
  logic [LO_W-1:0]  sel_lo;
  logic [1:0]       sel_adj;
  logic [HI_W-1:0]  sel_hi;
  logic [PC_W-1:0]  target;
  logic             take_nxt;

  logic             valid_d, valid_q;
  logic [PC_W-1:0]  pc_d, pc_q;
  logic             taken_d, taken_q;

  tbu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .opa (opa),
    .opb (opb),
    .lt  (c_lt),
    .eq  (c_eq),
    .gt  (c_gt)
  );

  tbu_unpack #(
    .IMM_W (IMM_W),
    .D3_W  (D3_W),
    .D2_W  (D2_W),
    .SUM_W (SUM_W),
    .FALL_B(FALL_B)
  ) u_unpack (
    .mode (mode),
    .imm  (imm),
    .d_lt (disp_v[CMP_LT]),
    .d_eq (disp_v[CMP_EQ]),
    .d_gt (disp_v[CMP_GT])
  );

  for (genvar g = 0; g < NC; g++) begin : g_cand
    tbu_lo_add #(.LO_W(LO_W)) u_lo (
      .pc_lo  (pc[LO_W-1:0]),
      .disp   (disp_v[g]),
      .sum_lo (cand_lo[g]),
      .adj    (cand_adj[g])
    );
  end

  always_comb begin
    if (c_lt)      outcome = CMP_LT;
    else if (c_eq) outcome = CMP_EQ;
    else           outcome = CMP_GT;
    sel_lo   = cand_lo[outcome];
    sel_adj  = cand_adj[outcome];
    take_nxt = !((mode == MODE_DUO) && (outcome == CMP_EQ));
  end

  tbu_hi_sel #(.HI_W(HI_W)) u_hi (
    .hi     (pc[PC_W-1:LO_W]),
    .adj    (sel_adj),
    .hi_out (sel_hi)
  );

  assign target = {sel_hi, sel_lo};

  always_comb begin
    valid_d = in_valid;
    pc_d    = pc_q;
    taken_d = taken_q;
    if (in_valid) begin
      pc_d    = target;
      taken_d = take_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      pc_q    <= pc_d;
      taken_q <= taken_d;
    end
  end

  assign out_valid = valid_q;
  assign next_pc   = pc_q;
  assign taken     = taken_q;

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(next_pc) && $stable(taken)));
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones({c_lt, c_eq, c_gt}) == 1));
  p_adj_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (sel_adj != 2'b10));
  p_tri_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_TRI) |=> taken);
  p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_DUO && opa == opb) |=>
      (!taken && next_pc == $past(pc) + PC_W'(FALL_B)));
endmodule

// File: tb/tb_tbu_branch3.sv
module tb_tbu_branch3;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        mode;
  logic [47:0] pc;
  logic [32:0] imm;
  logic [63:0] opa, opb;
  logic        out_valid;
  logic [47:0] next_pc;
  logic        taken;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  bit    exp_valid;
  logic [47:0] exp_pc;
  bit    exp_taken;
  string exp_tag;

  tbu_branch3 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .pc(pc),
    .imm(imm), .opa(opa), .opb(opb), .out_valid(out_valid),
    .next_pc(next_pc), .taken(taken)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_model(input bit m, input logic [47:0] p,
                                    input logic [32:0] i, input logic [63:0] a,
                                    input logic [63:0] b, output logic [47:0] npc,
                                    output bit tk);
    longint sa = a;
    longint sb = b;
    longint d;
    tk = 1'b1;
    if (!m) begin
      if (sa < sb)       d = longint'($signed(i[10:0]));
      else if (sa == sb) d = longint'($signed(i[21:11]));
      else               d = longint'($signed(i[32:22]));
    end else begin
      if (sa < sb)       d = longint'($signed(i[15:0]));
      else if (sa > sb)  d = longint'($signed(i[31:16]));
      else begin d = 8; tk = 1'b0; end
    end
    npc = 48'(longint'({16'h0, p}) + d);
  endfunction

  function automatic logic [32:0] tri_imm(int dl, int de, int dg);
    return {11'(dg), 11'(de), 11'(dl)};
  endfunction

  function automatic logic [32:0] duo_imm(int dlo, int dhi, bit top);
    return {top, 16'(dhi), 16'(dlo)};
  endfunction

  task automatic compare_now();
    chk(exp_tag, "out_valid", 64'(out_valid), 64'(exp_valid));
    chk(exp_tag, "next_pc", 64'(next_pc), 64'(exp_pc));
    chk(exp_tag, "taken", 64'(taken), 64'(exp_taken));
  endtask

  task automatic apply(bit v, bit m, logic [47:0] p, logic [32:0] i,
                       logic [63:0] a, logic [63:0] b, string tag);
    logic [47:0] npc;
    bit tk;
    @(negedge clk);
    compare_now();
    in_valid = v; mode = m; pc = p; imm = i; opa = a; opb = b;
    exp_valid = v;
    if (v) begin
      ref_model(m, p, i, a, b, npc, tk);
      exp_pc = npc;
      exp_taken = tk;
      exp_tag = tag;
    end else begin
      exp_tag = "R10";
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = 1'b0; pc = '0; imm = '0; opa = '0; opb = '0;
    exp_valid = 0; exp_pc = '0; exp_taken = 0; exp_tag = "R1";
    repeat (3) @(negedge clk);
    in_valid = 1'b1; pc = 48'h1234; imm = tri_imm(5, 6, 7);
    @(negedge clk);
    compare_now();            // R1: reset holds all outputs at zero despite a strobe
    in_valid = 1'b0;
    rst_n = 1'b1;

    // R3, R4, R5: three-way outcomes
    apply(1, 0, 48'h1234_5678_9ABC, tri_imm(-40, 100, 1000), -64'sd5, 64'sd3, "R3");
    apply(1, 0, 48'h1234_5678_9ABC, tri_imm(-40, 100, 1000), 64'd77, 64'd77, "R3");
    apply(1, 0, 48'h1234_5678_9ABC, tri_imm(-40, 100, 1000), 64'd9, 64'd2, "R5");
    // R4: signed compare across signs and at the most negative value
    apply(1, 0, 48'h0000_4000_0000, tri_imm(-1024, 0, 1023), 64'h7FFF_FFFF_FFFF_FFFF,
          64'h8000_0000_0000_0000, "R4");
    apply(1, 0, 48'h0000_4000_0000, tri_imm(-1024, 0, 1023), 64'h8000_0000_0000_0000,
          64'd0, "R4");
    apply(1, 0, 48'h0000_4000_0000, tri_imm(-1024, 0, 1023), 64'hFFFF_FFFF_FFFF_FFFF,
          64'd1, "R4");
    // R6: two-way, with imm[32] toggled
    apply(1, 1, 48'h00AB_0000_8000, duo_imm(-32768, 32767, 0), 64'd1, 64'd2, "R6");
    apply(1, 1, 48'h00AB_0000_8000, duo_imm(-32768, 32767, 1), 64'd3, 64'd2, "R6");
    apply(1, 1, 48'h00AB_0000_8000, duo_imm(-32768, 32767, 1), 64'd1, 64'd2, "R6");
    // R7: fall-through
    apply(1, 1, 48'h00AB_0000_8000, duo_imm(-4, 4, 1), 64'd42, 64'd42, "R7");
    apply(1, 1, 48'h0000_0000_FFFC, duo_imm(-4, 4, 0), 64'd0, 64'd0, "R7");
    // R9: carry and borrow across bit 16
    apply(1, 0, 48'h0000_1234_FFFC, tri_imm(16, 0, 0), 64'd0, 64'd1, "R9");
    apply(1, 0, 48'h0000_1234_0004, tri_imm(0, 0, -32), 64'd1, 64'd0, "R9");
    apply(1, 1, 48'h0000_1234_FFF0, duo_imm(0, 32767, 0), 64'd5, 64'd4, "R9");
    apply(1, 1, 48'h0000_1234_0010, duo_imm(-32768, 0, 0), 64'd4, 64'd5, "R9");
    // R8: wraparound both ways
    apply(1, 1, 48'hFFFF_FFFF_FFF8, duo_imm(0, 0, 0), 64'd7, 64'd7, "R8");
    apply(1, 0, 48'h0000_0000_0000, tri_imm(0, -4, 0), 64'd7, 64'd7, "R8");
    apply(1, 0, 48'hFFFF_FFFF_FF00, tri_imm(0, 0, 1000), 64'd8, 64'd7, "R8");
    // R10: idle cycles with changing inputs, then R2 valid drops
    apply(0, 1, 48'h5555_5555_5555, duo_imm(100, 200, 1), 64'd1, 64'd9, "R10");
    apply(0, 0, 48'hAAAA_AAAA_AAAA, tri_imm(3, 3, 3), 64'd9, 64'd1, "R10");
    apply(1, 0, 48'h0000_0001_0000, tri_imm(-8, 8, 0), 64'd1, 64'd2, "R2");

    // Random mix, half the PCs near 16-bit boundaries
    for (int n = 0; n < 600; n++) begin
      logic [47:0] rp;
      logic [63:0] ra, rb;
      bit rm, rv;
      rp = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: rp[15:0] = 16'hFFFF - 16'($urandom_range(0, 40));
        1: rp[15:0] = 16'($urandom_range(0, 40));
        default: ;
      endcase
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) rb = ra;
      if ($urandom_range(0, 3) == 0) rb = {ra[63], 63'($urandom)};
      rm = 1'($urandom);
      rv = ($urandom_range(0, 7) != 0);
      apply(rv, rm, rp, {1'($urandom), $urandom}, ra, rb, rm ? "R6" : "R5");
    end
    apply(0, 0, '0, '0, '0, '0, "R10");
    @(negedge clk);
    compare_now();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule